// File: doc/BRIEF.md
# USB Host Controller Status and Descriptor Event Updater

This block sits between a USB 1.1 style host controller's transaction engine and its software-visible state. It watches for single-cycle events: a protocol fault (illegal or corrupted packet identifier, or an illegal maximum length), a system-bus abort, and a resume seen on the bus. It also takes a stream of finished transactions. Each of these is a transfer descriptor control/status word plus a result code. From all of this it keeps the controller's run, configure and suspend controls and six status flags up to date. For each descriptor it emits the rewritten control/status word, with its error countdown applied.

Software uses a command write to set Run, Config and Suspend, and a write-1-to-clear strobe to acknowledge status flags. The descriptor path is valid/ready on both sides and holds one result in a register. `td_in_ready` is high when the output register is empty or is being drained in the same cycle. A word shown on `td_out_word` stays valid and unchanged until `td_out_ready` is seen high. Every register output changes on the clock edge after the inputs that cause it are sampled.

Top module: `usbh_status_evt`

## Requirements
- R1: `rst_n` low, or `hc_reset` high at a clock edge, clears `run`, `cfg`, `susp` and all six bits of `hc_status`. `hc_reset` beats every other input in the same cycle.
- R2: `ev_pid_err` clears `run` and sets `hc_status[4]` (process error) and `hc_status[5]` (halted) on the next clock.
- R3: `ev_bus_abort` clears `run` and sets `hc_status[3]` (system error) and `hc_status[5]` on the next clock.
- R4: A command write with Run=0 while `run` is 1 sets `hc_status[5]`. A command write with Run=1 while `run` is 0 and no halting event is present clears `hc_status[5]` on the next clock. A halting event in the same cycle wins, so `run` stays 0.
- R5: Suspend is taken only from a command write with Suspend=1 and Run=0 while `run` is already 0; otherwise `susp` becomes 0. `ev_resume` sets `hc_status[2]` only while `susp` is 1, and is ignored otherwise.
- R6: `sts_clr_wr` clears each of `hc_status[4:0]` whose `sts_clr_mask` bit is 1. A hardware set of the same bit in the same cycle wins. `hc_status[5]` cannot be cleared by this write.
- R7: Descriptor word layout with the default parameters: bit 15 Active, bit 14 Stalled, bit 13 data-buffer error, bit 12 CRC/time-out, bit 11 bit-stuff, bit 10 interrupt-on-complete, bits 9:8 error count, bits 7:0 pass through. Result codes 3 (CRC/time-out) and 4 (NAK or STALL answering a SETUP) set bit 12. For any error result, a nonzero count is decremented.
- R8: Result 5 (bit-stuff) sets bit 11 and result 6 (data buffer) sets bit 13. Both always set `hc_status[1]` (error interrupt).
- R9: When an error result takes the count from 1 to 0, Active is cleared, Stalled is set and `hc_status[1]` is set. A count of 0 is neither decremented nor causes a halt, and for results 3 and 4 it leaves `hc_status[1]` alone.
- R10: Result 2 (STALL handshake) clears Active, sets Stalled and sets `hc_status[1]`, leaving the count unchanged.
- R11: Result 0 (complete) clears Active and sets `hc_status[0]` when bit 10 is 1. Result 1 (short packet) clears Active and sets `hc_status[0]`. Result 7 (NAK) passes the word through unchanged and sets nothing.
- R12: A descriptor is accepted when `td_in_valid` and `td_in_ready` are both high, with `td_in_ready` = not `td_out_valid` or `td_out_ready`. Its updated word appears on the next clock and is held while `td_out_ready` is low.
- R13: A command write loads `cfg` from `cmd_wr_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| hc_reset | input | 1 | controller or global reset pulse |
| cmd_wr | input | 1 | command register write strobe |
| cmd_wr_run | input | 1 | Run value written |
| cmd_wr_cfg | input | 1 | Config value written |
| cmd_wr_susp | input | 1 | Suspend value written |
| sts_clr_wr | input | 1 | status write-1-to-clear strobe |
| sts_clr_mask | input | 5 | bits of hc_status[4:0] to clear |
| ev_pid_err | input | 1 | illegal/corrupt PID or illegal max length |
| ev_bus_abort | input | 1 | system bus master or target abort |
| ev_resume | input | 1 | resume signalling detected |
| td_in_valid | input | 1 | descriptor result valid |
| td_in_ready | output | 1 | descriptor result accepted |
| td_in_word | input | LEN_W+ERR_W+6 | descriptor control/status word before update |
| td_in_result | input | 3 | transaction result code |
| td_out_valid | output | 1 | updated word valid |
| td_out_ready | input | 1 | consumer takes updated word |
| td_out_word | output | LEN_W+ERR_W+6 | descriptor word to write back |
| run | output | 1 | Run/Stop |
| cfg | output | 1 | Config flag |
| susp | output | 1 | suspend mode |
| hc_status | output | 6 | {halted, process err, system err, resume, error int, int} |

## Verification
The bench builds the block with LEN_W=8 and ERR_W=2, so the descriptor word is 16 bits. The 2-bit count lets every count value be loaded directly: 3 and 2 reach a plain decrement, 1 reaches the halting transition and 0 the never-halting case, each within one descriptor. The output consumer is also throttled, so held words and a full output register meeting a new input are covered.

// File: rtl/usbh_evt_pkg.sv
package usbh_evt_pkg;

  typedef enum logic [2:0] {
    RES_DONE     = 3'd0,
    RES_SHORT    = 3'd1,
    RES_STALL    = 3'd2,
    RES_TIMEOUT  = 3'd3,
    RES_SETUP_HS = 3'd4,
    RES_STUFF    = 3'd5,
    RES_DBUF     = 3'd6,
    RES_NAK      = 3'd7
  } td_result_e;

  localparam int STS_W   = 6;
  localparam int CLR_W   = 5;
  localparam int ST_INT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_RES  = 2;
  localparam int ST_HSE  = 3;
  localparam int ST_HCPE = 4;
  localparam int ST_HALT = 5;

endpackage

// File: rtl/usbh_td_update.sv
module usbh_td_update
  import usbh_evt_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int ERR_W = 2,
  localparam int WORD_W = LEN_W + ERR_W + 6
) (
  input  logic [WORD_W-1:0] word_i,
  input  td_result_e        result_i,
  output logic [WORD_W-1:0] word_o,
  output logic              set_int_o,
  output logic              set_err_o
);

  localparam int P_CNT   = LEN_W;
  localparam int P_IOC   = LEN_W + ERR_W;
  localparam int P_STUFF = P_IOC + 1;
  localparam int P_CRC   = P_IOC + 2;
  localparam int P_DBUF  = P_IOC + 3;
  localparam int P_STALL = P_IOC + 4;
  localparam int P_ACT   = P_IOC + 5;

  logic [ERR_W-1:0] cnt;
  logic             is_err;

  always_comb begin
    word_o    = word_i;
    set_int_o = 1'b0;
    set_err_o = 1'b0;
    cnt       = word_i[P_CNT +: ERR_W];
    is_err    = 1'b0;
    unique case (result_i)
      RES_DONE: begin
        word_o[P_ACT] = 1'b0;
        set_int_o     = word_i[P_IOC];
      end
      RES_SHORT: begin
        word_o[P_ACT] = 1'b0;
        set_int_o     = 1'b1;
      end
      RES_STALL: begin
        word_o[P_ACT]   = 1'b0;
        word_o[P_STALL] = 1'b1;
        set_err_o       = 1'b1;
      end
      RES_TIMEOUT, RES_SETUP_HS: begin
        word_o[P_CRC] = 1'b1;
        is_err        = 1'b1;
      end
      RES_STUFF: begin
        word_o[P_STUFF] = 1'b1;
        set_err_o       = 1'b1;
        is_err          = 1'b1;
      end
      RES_DBUF: begin
        word_o[P_DBUF] = 1'b1;
        set_err_o      = 1'b1;
        is_err         = 1'b1;
      end
      default: ;
    endcase
    if (is_err && (cnt != '0)) begin
      word_o[P_CNT +: ERR_W] = cnt - ERR_W'(1);
      if (cnt == ERR_W'(1)) begin
        word_o[P_ACT]   = 1'b0;
        word_o[P_STALL] = 1'b1;
        set_err_o       = 1'b1;
      end
    end
  end

endmodule

// File: rtl/usbh_cmd_ctrl.sv
module usbh_cmd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hc_reset,
  input  logic cmd_wr,
  input  logic wr_run,
  input  logic wr_cfg,
  input  logic wr_susp,
  input  logic hw_halt,
  output logic run_o,
  output logic cfg_o,
  output logic susp_o,
  output logic halted_o
);

  logic run_nxt;

  always_comb begin
    run_nxt = run_o;
    if (cmd_wr)  run_nxt = wr_run;
    if (hw_halt) run_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o    <= 1'b0;
      cfg_o    <= 1'b0;
      susp_o   <= 1'b0;
      halted_o <= 1'b0;
    end else if (hc_reset) begin
      run_o    <= 1'b0;
      cfg_o    <= 1'b0;
      susp_o   <= 1'b0;
      halted_o <= 1'b0;
    end else begin
      run_o <= run_nxt;
      if (cmd_wr) begin
        cfg_o  <= wr_cfg;
        susp_o <= wr_susp & ~run_o & ~wr_run;
      end
      if (hw_halt || (run_o && !run_nxt))
        halted_o <= 1'b1;
      else if (!run_o && run_nxt)
        halted_o <= 1'b0;
    end
  end

endmodule

// File: rtl/usbh_sts_bits.sv
module usbh_sts_bits #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hc_reset,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] bits_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic b;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     b <= 1'b0;
      else if (hc_reset)              b <= 1'b0;
      else if (set_i[i])              b <= 1'b1;
      else if (clr_wr && clr_mask[i]) b <= 1'b0;
    end
    assign bits_o[i] = b;
  end

endmodule

// File: rtl/usbh_status_evt.sv
module usbh_status_evt
  import usbh_evt_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int ERR_W = 2,
  localparam int WORD_W = LEN_W + ERR_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hc_reset,
  input  logic              cmd_wr,
  input  logic              cmd_wr_run,
  input  logic              cmd_wr_cfg,
  input  logic              cmd_wr_susp,
  input  logic              sts_clr_wr,
  input  logic [CLR_W-1:0]  sts_clr_mask,
  input  logic              ev_pid_err,
  input  logic              ev_bus_abort,
  input  logic              ev_resume,
  input  logic              td_in_valid,
  output logic              td_in_ready,
  input  logic [WORD_W-1:0] td_in_word,
  input  logic [2:0]        td_in_result,
  output logic              td_out_valid,
  input  logic              td_out_ready,
  output logic [WORD_W-1:0] td_out_word,
  output logic              run,
  output logic              cfg,
  output logic              susp,
  output logic [STS_W-1:0]  hc_status
);

  logic              td_fire;
  logic [WORD_W-1:0] upd_word;
  logic              upd_int;
  logic              upd_err;
  logic              halted;
  logic [CLR_W-1:0]  sts_set;
  logic [CLR_W-1:0]  sts_q;

  assign td_in_ready = !td_out_valid || td_out_ready;
  assign td_fire     = td_in_valid && td_in_ready;

  usbh_td_update #(.LEN_W(LEN_W), .ERR_W(ERR_W)) u_upd (
    .word_i    (td_in_word),
    .result_i  (td_result_e'(td_in_result)),
    .word_o    (upd_word),
    .set_int_o (upd_int),
    .set_err_o (upd_err)
  );

  usbh_cmd_ctrl u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .hc_reset (hc_reset),
    .cmd_wr   (cmd_wr),
    .wr_run   (cmd_wr_run),
    .wr_cfg   (cmd_wr_cfg),
    .wr_susp  (cmd_wr_susp),
    .hw_halt  (ev_pid_err | ev_bus_abort),
    .run_o    (run),
    .cfg_o    (cfg),
    .susp_o   (susp),
    .halted_o (halted)
  );

  always_comb begin
    sts_set          = '0;
    sts_set[ST_INT]  = td_fire & upd_int;
    sts_set[ST_ERR]  = td_fire & upd_err;
    sts_set[ST_RES]  = ev_resume & susp;
    sts_set[ST_HSE]  = ev_bus_abort;
    sts_set[ST_HCPE] = ev_pid_err;
  end

  usbh_sts_bits #(.N(CLR_W)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .hc_reset (hc_reset),
    .set_i    (sts_set),
    .clr_wr   (sts_clr_wr),
    .clr_mask (sts_clr_mask),
    .bits_o   (sts_q)
  );

  assign hc_status = {halted, sts_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      td_out_valid <= 1'b0;
      td_out_word  <= '0;
    end else if (td_fire) begin
      td_out_valid <= 1'b1;
      td_out_word  <= upd_word;
    end else if (td_out_ready) begin
      td_out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/usbh_status_evt_chk.sv
module usbh_status_evt_chk
  import usbh_evt_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hc_reset,
  input logic              cmd_wr,
  input logic              cmd_wr_run,
  input logic              sts_clr_wr,
  input logic [CLR_W-1:0]  sts_clr_mask,
  input logic              ev_pid_err,
  input logic              ev_bus_abort,
  input logic              run,
  input logic              cfg,
  input logic              susp,
  input logic [STS_W-1:0]  hc_status,
  input logic              td_out_valid,
  input logic              td_out_ready,
  input logic [WORD_W-1:0] td_out_word
);

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hc_reset |=> (hc_status == '0) && !run && !cfg && !susp);

  p_pid_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pid_err && !hc_reset) |=> !run && hc_status[ST_HALT] && hc_status[ST_HCPE]);

  p_abort_halts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bus_abort && !hc_reset) |=> !run && hc_status[ST_HALT] && hc_status[ST_HSE]);

  p_run_unhalts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_wr_run && !ev_pid_err && !ev_bus_abort && !hc_reset)
      |=> run && !hc_status[ST_HALT]);

  p_susp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> !run);

  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bus_abort && sts_clr_wr && sts_clr_mask[ST_HSE] && !hc_reset)
      |=> hc_status[ST_HSE]);

  p_hold_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (td_out_valid && !td_out_ready) |=> td_out_valid && $stable(td_out_word));

endmodule

bind usbh_status_evt usbh_status_evt_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/usbh_status_evt_test.sv
module usbh_status_evt_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hc_reset = 1'b0;
  logic        cmd_wr = 1'b0, cmd_wr_run = 1'b0, cmd_wr_cfg = 1'b0, cmd_wr_susp = 1'b0;
  logic        sts_clr_wr = 1'b0;
  logic [4:0]  sts_clr_mask = '0;
  logic        ev_pid_err = 1'b0, ev_bus_abort = 1'b0, ev_resume = 1'b0;
  logic        td_in_valid = 1'b0;
  logic        td_in_ready;
  logic [15:0] td_in_word = '0;
  logic [2:0]  td_in_result = '0;
  logic        td_out_valid;
  logic        td_out_ready = 1'b1;
  logic [15:0] td_out_word;
  logic        run, cfg, susp;
  logic [5:0]  hc_status;

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  bit    gap_mode = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  usbh_status_evt uut (.*);

  // reference model state
  logic        m_run, m_cfg, m_susp, m_ov;
  logic [5:0]  m_sts;
  logic [15:0] m_ow;

  task automatic model_td(input logic [15:0] w, input int res,
                          output logic [15:0] nw, output bit si, output bit se);
    int  cnt;
    bit  err;
    cnt = (w >> 8) & 3;
    nw  = w;
    si  = 0;
    se  = 0;
    err = (res >= 3 && res <= 6);
    if (res == 0) begin nw[15] = 0; si = w[10]; end
    if (res == 1) begin nw[15] = 0; si = 1; end
    if (res == 2) begin nw[15] = 0; nw[14] = 1; se = 1; end
    if (res == 3 || res == 4) nw[12] = 1;
    if (res == 5) begin nw[11] = 1; se = 1; end
    if (res == 6) begin nw[13] = 1; se = 1; end
    if (err && cnt > 0) begin
      nw[9:8] = 2'(cnt - 1);
      if (cnt == 1) begin nw[15] = 0; nw[14] = 1; se = 1; end
    end
  endtask

  always @(posedge clk) begin
    bit          fire, si, se, hh, old_run, new_run;
    logic [15:0] nw;
    logic [5:0]  set;
    if (!rst_n) begin
      m_run = 0; m_cfg = 0; m_susp = 0; m_sts = '0; m_ov = 0; m_ow = '0;
    end else begin
      fire = td_in_valid && (!m_ov || td_out_ready);
      nw = '0; si = 0; se = 0;
      if (fire) model_td(td_in_word, int'(td_in_result), nw, si, se);
      if (hc_reset) begin
        m_run = 0; m_cfg = 0; m_susp = 0; m_sts = '0;
      end else begin
        hh  = ev_pid_err || ev_bus_abort;
        set = '0;
        set[0] = fire && si;
        set[1] = fire && se;
        set[2] = ev_resume && m_susp;
        set[3] = ev_bus_abort;
        set[4] = ev_pid_err;
        for (int i = 0; i < 5; i++) begin
          if (set[i]) m_sts[i] = 1;
          else if (sts_clr_wr && sts_clr_mask[i]) m_sts[i] = 0;
        end
        old_run = m_run;
        new_run = cmd_wr ? cmd_wr_run : m_run;
        if (hh) new_run = 0;
        if (cmd_wr) begin
          m_cfg  = cmd_wr_cfg;
          m_susp = cmd_wr_susp && !old_run && !cmd_wr_run;
        end
        if (hh || (old_run && !new_run)) m_sts[5] = 1;
        else if (!old_run && new_run) m_sts[5] = 0;
        m_run = new_run;
      end
      if (fire) begin m_ov = 1; m_ow = nw; end
      else if (td_out_ready) m_ov = 0;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    logic [26:0] got, exp;
    if (rst_n && !done) begin
      got = {run, cfg, susp, hc_status, td_in_ready, td_out_valid,
             (td_out_valid ? td_out_word : 16'h0)};
      exp = {m_run, m_cfg, m_susp, m_sts, (!m_ov || td_out_ready), m_ov,
             (m_ov ? m_ow : 16'h0)};
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s cycle %0d: got %h expected %h", cur_req, cyc, got, exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog %s: got cycle %0d expected below %0d", cur_req, cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
    hc_reset = 0; cmd_wr = 0; sts_clr_wr = 0;
    ev_pid_err = 0; ev_bus_abort = 0; ev_resume = 0;
    td_out_ready = gap_mode ? (cyc % 3 == 0) : 1'b1;
  endtask

  task automatic wr_cmd(input bit r, input bit c, input bit s);
    cmd_wr = 1; cmd_wr_run = r; cmd_wr_cfg = c; cmd_wr_susp = s;
    tick();
  endtask

  task automatic clr_sts(input logic [4:0] m);
    sts_clr_wr = 1; sts_clr_mask = m;
    tick();
  endtask

  task automatic send_td(input logic [15:0] w, input int res);
    bit f;
    td_in_valid = 1; td_in_word = w; td_in_result = 3'(res);
    forever begin
      f = td_in_ready;
      tick();
      if (f) break;
    end
    td_in_valid = 0;
  endtask

  function automatic logic [15:0] mk(bit ioc, int cnt, logic [7:0] len);
    return {1'b1, 4'b0000, ioc, 2'(cnt), len};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    cur_req = "R1"; tick(); tick();

    cur_req = "R13"; wr_cmd(0, 1, 0); tick();
    cur_req = "R4";
    wr_cmd(1, 1, 0); tick();
    wr_cmd(0, 1, 0); tick();
    wr_cmd(1, 1, 0); tick();
    ev_pid_err = 1; cmd_wr = 1; cmd_wr_run = 1; tick(); tick();
    cur_req = "R2"; wr_cmd(1, 1, 0); ev_pid_err = 1; tick(); tick();
    cur_req = "R3"; wr_cmd(1, 1, 0); ev_bus_abort = 1; tick(); tick();
    cur_req = "R6";
    clr_sts(5'b11111); tick();
    ev_bus_abort = 1; sts_clr_wr = 1; sts_clr_mask = 5'b11000; tick(); tick();
    clr_sts(5'b01000); tick();
    cur_req = "R5";
    ev_resume = 1; tick(); tick();
    wr_cmd(1, 1, 0);
    wr_cmd(1, 1, 1); tick();
    wr_cmd(0, 1, 1); tick();
    wr_cmd(0, 1, 1); tick();
    ev_resume = 1; tick(); tick();
    wr_cmd(0, 1, 0); ev_resume = 1; tick(); tick();
    clr_sts(5'b11111);

    cur_req = "R7";
    send_td(mk(0, 3, 8'h12), 3); tick();
    send_td(mk(0, 2, 8'h34), 4); tick();
    cur_req = "R9";
    send_td(mk(0, 1, 8'h40), 3); tick();
    clr_sts(5'b11111);
    send_td(mk(0, 0, 8'h41), 4); tick();
    cur_req = "R8";
    send_td(mk(0, 2, 8'h55), 5); tick();
    clr_sts(5'b00010);
    send_td(mk(0, 1, 8'h56), 6); tick();
    clr_sts(5'b00010);
    send_td(mk(0, 0, 8'h57), 5); tick();
    cur_req = "R10";
    clr_sts(5'b11111);
    send_td(mk(0, 3, 8'h66), 2); tick();
    cur_req = "R11";
    clr_sts(5'b11111);
    send_td(mk(0, 3, 8'h70), 0); tick();
    send_td(mk(1, 3, 8'h71), 0); tick();
    clr_sts(5'b00001);
    send_td(mk(0, 2, 8'h72), 1); tick();
    clr_sts(5'b00001);
    send_td(mk(1, 1, 8'h73), 7); tick();

    cur_req = "R12";
    gap_mode = 1;
    for (int k = 0; k < 12; k++) begin
      td_in_valid = 1; td_in_word = mk(k[0], k % 4, 8'(k)); td_in_result = 3'(k % 8);
      tick();
    end
    td_in_valid = 0;
    for (int k = 0; k < 16; k++) send_td(mk(k[1], k % 4, 8'(8'h80 + k)), k % 8);
    gap_mode = 0;
    repeat (4) tick();

    cur_req = "R1";
    wr_cmd(1, 1, 0);
    ev_pid_err = 1; tick();
    hc_reset = 1; ev_bus_abort = 1; cmd_wr = 1; cmd_wr_run = 1; cmd_wr_cfg = 1; tick();
    tick(); tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule